// File: doc/BRIEF.md
# Receive Frame Page Store

This block takes the word stream of received frames (already accepted by the address filter) and stores each one in a paged 16-bit word memory. At the first word of a frame it takes the lowest free packet number and a free physical page, and it takes more pages as the frame crosses page boundaries. Each payload word goes to a logical word index of the packet. A per-packet page list turns that index into a physical memory address. The same translation is offered on a separate lookup port so that software can find its way through a stored packet.

When the last word has been written, the block fills in two header words at the front of the packet: a status word and the total byte count. It then either places the packet number in a receive queue or discards the packet. A good CRC always queues; a bad CRC queues only when a control input allows it. A non-empty queue raises the interrupt. Software frees the packet at the head of the queue with a single release pulse, which returns both its pages and its number. When no page or packet number is free, the frame is dropped and everything it held is returned. The frame source must leave at least two idle cycles after each last word while the header is written. Words arriving during those two cycles are ignored.

Top module: `rxb_rx_alloc`

## Requirements
- R1: At the first word of a frame the block assigns the lowest-numbered free packet number and takes a free page. If either is missing, the whole frame is dropped and nothing is written.
- R2: Payload word k of a frame is stored at logical word k+2. Logical word w lies in page-list slot w/PAGE_WORDS at offset w%PAGE_WORDS, and its physical address is {page index, offset}. The port tr_pkt/tr_word returns this address combinationally as tr_addr.
- R3: If a frame needs a new page and none is free, or its page list already holds MAX_PAGES pages, the frame is dropped. Its pages and its packet number are freed, it is never queued, and no further word of it is written.
- R4: After the last word, logical word 0 receives the status word and logical word 1 receives the byte count 2*(payload words + 2). The status word has bit 0 set for a bad CRC, bit 1 for a long frame and bit 2 for a short frame; all other bits are 0.
- R5: A packet is queued when rx_crc_ok was high with its last word, or when allow_bad_crc is high. Otherwise its pages and number are freed and it is not queued.
- R6: rx_irq is high exactly while the receive queue holds a packet. rx_head_pkt shows the oldest queued packet number, so packets leave in arrival order.
- R7: A rel_cmd pulse removes the head of the queue and frees its pages and its packet number for reuse. A pulse while the queue is empty has no effect.
- R8: A frame whose first word arrives while rx_enable is low is discarded with no memory write.
- R9: A frame is long when its payload bytes exceed MAX_FRAME_BYTES and short when its payload bytes are below MIN_FRAME_BYTES. Payload bytes equal exactly to either limit set neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receive enable, sampled at the first word of a frame |
| allow_bad_crc | input | 1 | Queue packets with a failed CRC as well |
| rx_valid | input | 1 | Receive word valid |
| rx_data | input | 16 | Receive word |
| rx_last | input | 1 | Marks the last word of a frame |
| rx_crc_ok | input | 1 | CRC result, valid with rx_last |
| rel_cmd | input | 1 | Remove and release the head packet |
| rx_irq | output | 1 | Receive queue not empty |
| rx_head_pkt | output | PKT_W | Packet number at the head of the queue |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | PG_W+OFF_W | Packet memory physical word address |
| mem_wdata | output | 16 | Packet memory write data |
| tr_pkt | input | PKT_W | Lookup packet number |
| tr_word | input | WIDX_W | Lookup logical word index |
| tr_addr | output | PG_W+OFF_W | Translated physical address |

## Verification
A payload word sampled at a clock edge appears on the memory write port right after that same edge. The status word follows one edge after the last word and the byte count two edges after it; the queue entry and rx_irq change at that second edge. A release pulse changes rx_irq and rx_head_pkt at the edge that samples it. The bench drives on falling edges and samples on falling edges. It rebuilds memory from the write port and reads it back through the lookup port only three cycles after a frame's last word. It checks the queue one falling edge after each release, so every result is read after its last update.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_DROP,
    ST_HDR0,
    ST_HDR1
  } rxb_state_e;

  localparam int unsigned STS_BAD_CRC = 0;
  localparam int unsigned STS_LONG    = 1;
  localparam int unsigned STS_SHORT   = 2;

  // bytes held by a number of 16-bit words
  function automatic logic [15:0] words_to_bytes(input logic [15:0] words);
    return {words[14:0], 1'b0};
  endfunction

  // header status word from the CRC result and the payload size
  function automatic logic [15:0] status_word(input logic crc_good,
                                              input logic [15:0] pay_bytes,
                                              input logic [15:0] min_b,
                                              input logic [15:0] max_b);
    logic [15:0] s;
    s = '0;
    s[STS_BAD_CRC] = !crc_good;
    s[STS_LONG]    = pay_bytes > max_b;
    s[STS_SHORT]   = pay_bytes < min_b;
    return s;
  endfunction

endpackage

// File: rtl/rxb_free_map.sv
module rxb_free_map #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [N-1:0]  free_mask,
  output logic          avail,
  output logic [IW-1:0] idx
);

  logic [N-1:0] used_q;
  logic [N-1:0] take_mask;

  // lowest free entry wins
  always_comb begin
    avail = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        avail = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    take_mask = '0;
    if (take && avail) take_mask[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= (used_q & ~free_mask) | take_mask;
  end

endmodule

// File: rtl/rxb_pkt_fifo.sv
module rxb_pkt_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 6,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic [CW-1:0] count
);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (int'(count) < DEPTH);
  assign head    = slot_q[rp_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/rxb_page_table.sv
module rxb_page_table #(
  parameter int NUM_PKTS  = 64,
  parameter int NUM_PAGES = 32,
  parameter int MAX_PAGES = 4,
  parameter int PKT_W     = $clog2(NUM_PKTS),
  parameter int PG_W      = $clog2(NUM_PAGES),
  parameter int SLOT_W    = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1,
  parameter int CNT_W     = $clog2(MAX_PAGES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  // append a page to a packet's list
  input  logic                       wr_en,
  input  logic [PKT_W-1:0]           wr_pkt,
  input  logic [SLOT_W-1:0]          wr_slot,
  input  logic [PG_W-1:0]            wr_page,
  // two lookup ports: slot -> page
  input  logic [1:0][PKT_W-1:0]      lk_pkt,
  input  logic [1:0][SLOT_W-1:0]     lk_slot,
  output logic [1:0][PG_W-1:0]       lk_page,
  // two free ports: packet -> mask of owned pages
  input  logic [1:0][PKT_W-1:0]      fr_pkt,
  output logic [1:0][NUM_PAGES-1:0]  fr_mask
);

  logic [PG_W-1:0]  pg_q  [NUM_PKTS][MAX_PAGES];
  logic [CNT_W-1:0] cnt_q [NUM_PKTS];

  always_ff @(posedge clk) begin
    if (wr_en) pg_q[wr_pkt][wr_slot] <= wr_page;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PKTS; p++) cnt_q[p] <= '0;
    end else if (wr_en) begin
      cnt_q[wr_pkt] <= CNT_W'(wr_slot) + 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_port
    assign lk_page[g] = pg_q[lk_pkt[g]][lk_slot[g]];

    always_comb begin
      fr_mask[g] = '0;
      for (int s = 0; s < MAX_PAGES; s++) begin
        if (s < int'(cnt_q[fr_pkt[g]])) fr_mask[g][pg_q[fr_pkt[g]][s]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxb_rx_alloc.sv
module rxb_rx_alloc
  import rxb_pkg::*;
#(
  parameter int NUM_PKTS        = 64,
  parameter int NUM_PAGES       = 32,
  parameter int PAGE_WORDS      = 1024,
  parameter int MAX_PAGES       = 4,
  parameter int MIN_FRAME_BYTES = 64,
  parameter int MAX_FRAME_BYTES = 1518,
  parameter int PKT_W           = $clog2(NUM_PKTS),
  parameter int PG_W            = $clog2(NUM_PAGES),
  parameter int OFF_W           = $clog2(PAGE_WORDS),
  parameter int WIDX_W          = $clog2(MAX_PAGES * PAGE_WORDS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_enable,
  input  logic                   allow_bad_crc,
  input  logic                   rx_valid,
  input  logic [15:0]            rx_data,
  input  logic                   rx_last,
  input  logic                   rx_crc_ok,
  input  logic                   rel_cmd,
  output logic                   rx_irq,
  output logic [PKT_W-1:0]       rx_head_pkt,
  output logic                   mem_we,
  output logic [PG_W+OFF_W-1:0]  mem_addr,
  output logic [15:0]            mem_wdata,
  input  logic [PKT_W-1:0]       tr_pkt,
  input  logic [WIDX_W-1:0]      tr_word,
  output logic [PG_W+OFF_W-1:0]  tr_addr
);

  localparam int SLOT_W = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
  localparam int QCNT_W = $clog2(NUM_PKTS + 1);
  localparam int ADDR_W = PG_W + OFF_W;
  localparam logic [15:0] MIN_B = 16'(MIN_FRAME_BYTES);
  localparam logic [15:0] MAX_B = 16'(MAX_FRAME_BYTES);

  rxb_state_e          st_q;
  logic [PKT_W-1:0]    cur_pkt_q;
  logic [WIDX_W-1:0]   widx_q;
  logic                crc_q;

  // named internal events
  logic ev_start, ev_blocked, ev_cross, ev_grow, ev_overrun;
  logic ev_store, ev_hdr0, ev_hdr1, ev_push, ev_crc_drop, ev_pop;
  logic push_ok;

  logic              pkt_avail, page_avail;
  logic [PKT_W-1:0]  pkt_idx;
  logic [PG_W-1:0]   page_idx;
  logic [NUM_PKTS-1:0]  pkt_free_mask;
  logic [NUM_PAGES-1:0] page_free_mask;

  logic [OFF_W-1:0]  woff;
  logic [WIDX_W-1:0] wslot_full;
  logic [SLOT_W-1:0] wslot;

  logic [1:0][PKT_W-1:0]     lk_pkt, fr_pkt;
  logic [1:0][SLOT_W-1:0]    lk_slot;
  logic [1:0][PG_W-1:0]      lk_page;
  logic [1:0][NUM_PAGES-1:0] fr_mask;

  logic              fifo_empty;
  logic [QCNT_W-1:0] fifo_cnt;

  logic [ADDR_W-1:0] wr_addr_d;
  logic [15:0]       wr_data_d;
  logic              wr_en_d;
  logic [15:0]       pay_bytes;

  // ---------------- event decode ----------------
  assign woff       = widx_q[OFF_W-1:0];
  assign wslot_full = widx_q >> OFF_W;
  assign wslot      = SLOT_W'(wslot_full);

  assign ev_start    = (st_q == ST_IDLE) && rx_valid && rx_enable && pkt_avail && page_avail;
  assign ev_blocked  = (st_q == ST_IDLE) && rx_valid && !ev_start;
  assign ev_cross    = (st_q == ST_STORE) && rx_valid && (woff == '0);
  assign ev_grow     = ev_cross && (int'(wslot_full) < MAX_PAGES) && page_avail;
  assign ev_overrun  = ev_cross && !ev_grow;
  assign ev_store    = ev_start || ((st_q == ST_STORE) && rx_valid && !ev_overrun);
  assign ev_hdr0     = (st_q == ST_HDR0);
  assign ev_hdr1     = (st_q == ST_HDR1);
  assign push_ok     = crc_q || allow_bad_crc;
  assign ev_push     = ev_hdr1 && push_ok;
  assign ev_crc_drop = ev_hdr1 && !push_ok;
  assign ev_pop      = rel_cmd && !fifo_empty;

  // ---------------- allocators ----------------
  rxb_free_map #(.N(NUM_PKTS), .IW(PKT_W)) u_pkt_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ev_start),
    .free_mask (pkt_free_mask),
    .avail     (pkt_avail),
    .idx       (pkt_idx)
  );

  rxb_free_map #(.N(NUM_PAGES), .IW(PG_W)) u_page_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ev_start || ev_grow),
    .free_mask (page_free_mask),
    .avail     (page_avail),
    .idx       (page_idx)
  );

  always_comb begin
    pkt_free_mask = '0;
    if (ev_overrun || ev_crc_drop) pkt_free_mask[cur_pkt_q] = 1'b1;
    if (ev_pop)                    pkt_free_mask[rx_head_pkt] = 1'b1;
  end

  always_comb begin
    page_free_mask = '0;
    if (ev_overrun || ev_crc_drop) page_free_mask = page_free_mask | fr_mask[0];
    if (ev_pop)                    page_free_mask = page_free_mask | fr_mask[1];
  end

  // ---------------- page table ----------------
  assign lk_pkt[0]  = cur_pkt_q;
  assign lk_slot[0] = (ev_hdr0 || ev_hdr1) ? '0 : wslot;
  assign lk_pkt[1]  = tr_pkt;
  assign lk_slot[1] = SLOT_W'(tr_word >> OFF_W);
  assign fr_pkt[0]  = cur_pkt_q;
  assign fr_pkt[1]  = rx_head_pkt;

  rxb_page_table #(
    .NUM_PKTS (NUM_PKTS),
    .NUM_PAGES(NUM_PAGES),
    .MAX_PAGES(MAX_PAGES),
    .PKT_W    (PKT_W),
    .PG_W     (PG_W),
    .SLOT_W   (SLOT_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ev_start || ev_grow),
    .wr_pkt  (ev_start ? pkt_idx : cur_pkt_q),
    .wr_slot (ev_start ? '0 : wslot),
    .wr_page (page_idx),
    .lk_pkt  (lk_pkt),
    .lk_slot (lk_slot),
    .lk_page (lk_page),
    .fr_pkt  (fr_pkt),
    .fr_mask (fr_mask)
  );

  assign tr_addr = {lk_page[1], tr_word[OFF_W-1:0]};

  // ---------------- receive queue ----------------
  rxb_pkt_fifo #(.DEPTH(NUM_PKTS), .W(PKT_W), .CW(QCNT_W)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_push),
    .din   (cur_pkt_q),
    .pop   (rel_cmd),
    .head  (rx_head_pkt),
    .empty (fifo_empty),
    .count (fifo_cnt)
  );

  assign rx_irq = !fifo_empty;

  // ---------------- write port ----------------
  assign pay_bytes = words_to_bytes(16'(widx_q) - 16'd2);

  always_comb begin
    wr_en_d   = 1'b0;
    wr_addr_d = '0;
    wr_data_d = rx_data;
    if (ev_start) begin
      wr_en_d   = 1'b1;
      wr_addr_d = {page_idx, OFF_W'(2)};
    end else if (ev_store) begin
      wr_en_d   = 1'b1;
      wr_addr_d = ev_grow ? {page_idx, OFF_W'(0)} : {lk_page[0], woff};
    end else if (ev_hdr0) begin
      wr_en_d   = 1'b1;
      wr_addr_d = {lk_page[0], OFF_W'(0)};
      wr_data_d = status_word(crc_q, pay_bytes, MIN_B, MAX_B);
    end else if (ev_hdr1) begin
      wr_en_d   = 1'b1;
      wr_addr_d = {lk_page[0], OFF_W'(1)};
      wr_data_d = words_to_bytes(16'(widx_q));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= wr_en_d;
      mem_addr  <= wr_addr_d;
      mem_wdata <= wr_data_d;
    end
  end

  // ---------------- frame state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_pkt_q <= '0;
      widx_q    <= '0;
      crc_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ev_start) begin
            cur_pkt_q <= pkt_idx;
            widx_q    <= WIDX_W'(3);
            crc_q     <= rx_crc_ok;
            st_q      <= rx_last ? ST_HDR0 : ST_STORE;
          end else if (ev_blocked && !rx_last) begin
            st_q <= ST_DROP;
          end
        end
        ST_STORE: begin
          if (rx_valid) begin
            if (ev_overrun) begin
              st_q <= rx_last ? ST_IDLE : ST_DROP;
            end else begin
              widx_q <= widx_q + 1'b1;
              if (rx_last) begin
                crc_q <= rx_crc_ok;
                st_q  <= ST_HDR0;
              end
            end
          end
        end
        ST_DROP:  if (rx_valid && rx_last) st_q <= ST_IDLE;
        ST_HDR0:  st_q <= ST_HDR1;
        ST_HDR1:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 10,
  parameter int CNT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              rx_valid,
  input logic              rx_irq,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              st_idle,
  input logic              ev_hdr0,
  input logic              ev_hdr1,
  input logic              ev_push,
  input logic              ev_pop,
  input logic              ev_overrun,
  input logic              ev_crc_drop,
  input logic [CNT_W-1:0]  fifo_cnt
);

  // R4: status goes to word 0 of the packet's first page
  assert_hdr_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr0 |=> mem_we && (mem_addr[OFF_W-1:0] == '0));

  // R4: byte count goes to word 1
  assert_hdr_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr1 |=> mem_we && (mem_addr[OFF_W-1:0] == OFF_W'(1)));

  // R8: a frame start while disabled writes nothing
  assert_disabled_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && rx_valid && !rx_enable) |=> !mem_we);

  // R3: the word that overruns is not written
  assert_overrun_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> !mem_we);

  // R6: the interrupt only rises after a packet was queued
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(ev_push));

  // R7: a release alone shrinks the queue by one
  assert_release_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && !ev_push) |=> fifo_cnt == $past(fifo_cnt) - 1'b1);

  // R5: a frame ends in at most one of queue, CRC drop, overrun drop
  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_push, ev_crc_drop, ev_overrun}));

endmodule

bind rxb_rx_alloc rxb_checker #(
  .ADDR_W(PG_W + OFF_W),
  .OFF_W (OFF_W),
  .CNT_W ($clog2(NUM_PKTS + 1))
) u_rxb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_enable   (rx_enable),
  .rx_valid    (rx_valid),
  .rx_irq      (rx_irq),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .st_idle     (st_q == rxb_pkg::ST_IDLE),
  .ev_hdr0     (ev_hdr0),
  .ev_hdr1     (ev_hdr1),
  .ev_push     (ev_push),
  .ev_pop      (ev_pop),
  .ev_overrun  (ev_overrun),
  .ev_crc_drop (ev_crc_drop),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/tb_rxb_rx_alloc.sv
module tb_rxb_rx_alloc;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PKTS   = 64;
  localparam int NUM_PAGES  = 6;
  localparam int PAGE_WORDS = 8;
  localparam int MAX_PAGES  = 3;
  localparam int MIN_B      = 8;
  localparam int MAX_B      = 30;
  localparam int PKT_W      = $clog2(NUM_PKTS);
  localparam int PG_W       = $clog2(NUM_PAGES);
  localparam int OFF_W      = $clog2(PAGE_WORDS);
  localparam int WIDX_W     = $clog2(MAX_PAGES * PAGE_WORDS + 1);
  localparam int ADDR_W     = PG_W + OFF_W;

  // {payload words[7:0], crc_ok, allow_bad, expect queued, expect status[2:0]}
  localparam int NVEC = 8;
  localparam logic [13:0] VEC [NVEC] = '{
    {8'd6,  1'b1, 1'b0, 1'b1, 3'd0},
    {8'd2,  1'b1, 1'b0, 1'b1, 3'd4},
    {8'd16, 1'b1, 1'b0, 1'b1, 3'd2},
    {8'd6,  1'b0, 1'b0, 1'b0, 3'd0},
    {8'd6,  1'b0, 1'b1, 1'b1, 3'd1},
    {8'd20, 1'b0, 1'b1, 1'b1, 3'd3},
    {8'd4,  1'b1, 1'b0, 1'b1, 3'd0},
    {8'd15, 1'b1, 1'b0, 1'b1, 3'd0}
  };

  logic clk = 1'b0;
  logic rst_n, rx_enable, allow_bad_crc, rx_valid, rx_last, rx_crc_ok, rel_cmd;
  logic [15:0] rx_data;
  logic rx_irq, mem_we;
  logic [PKT_W-1:0]  rx_head_pkt, tr_pkt;
  logic [ADDR_W-1:0] mem_addr, tr_addr;
  logic [15:0]       mem_wdata;
  logic [WIDX_W-1:0] tr_word;

  logic [15:0] mem_model [1 << ADDR_W];
  int wr_count = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxb_rx_alloc #(
    .NUM_PKTS(NUM_PKTS), .NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS),
    .MAX_PAGES(MAX_PAGES), .MIN_FRAME_BYTES(MIN_B), .MAX_FRAME_BYTES(MAX_B)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .allow_bad_crc(allow_bad_crc),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_crc_ok(rx_crc_ok),
    .rel_cmd(rel_cmd), .rx_irq(rx_irq), .rx_head_pkt(rx_head_pkt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tr_pkt(tr_pkt), .tr_word(tr_word),
    .tr_addr(tr_addr)
  );

  // memory model fed from the write port, sampled between edges
  always @(negedge clk) begin
    if (mem_we) begin
      mem_model[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input logic crc, input int base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_data   = 16'(base + k);
      rx_last   = (k == n - 1);
      rx_crc_ok = crc;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic release_head();
    @(negedge clk);
    rel_cmd = 1'b1;
    @(negedge clk);
    rel_cmd = 1'b0;
  endtask

  task automatic read_word(input int pkt, input int w, output int val);
    tr_pkt  = PKT_W'(pkt);
    tr_word = WIDX_W'(w);
    #1;
    val = int'(mem_model[tr_addr]);
  endtask

  task automatic check_payload(input string req, input int pkt, input int n, input int base);
    int v;
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      read_word(pkt, k + 2, v);
      if (v != ((base + k) & 16'hffff)) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int n;
    rst_n = 1'b0; rx_enable = 1'b1; allow_bad_crc = 1'b0; rx_valid = 1'b0;
    rx_data = '0; rx_last = 1'b0; rx_crc_ok = 1'b0; rel_cmd = 1'b0;
    tr_pkt = '0; tr_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R6)
    chk("R6 reset irq", int'(rx_irq), 0);
    chk("R6 reset no write", wr_count, 0);

    // table of frames, each released afterwards (R2 R4 R5 R9 R1)
    for (int i = 0; i < NVEC; i++) begin
      n = int'(VEC[i][13:6]);
      allow_bad_crc = VEC[i][4];
      send_frame(n, VEC[i][5], i * 256);
      chk($sformatf("R5 vec%0d queued", i), int'(rx_irq), int'(VEC[i][3]));
      if (VEC[i][3]) begin
        chk($sformatf("R1 vec%0d pkt", i), int'(rx_head_pkt), 0);
        read_word(0, 0, v);
        chk($sformatf("R4 R9 vec%0d status", i), v, int'(VEC[i][2:0]));
        read_word(0, 1, v);
        chk($sformatf("R4 vec%0d byte count", i), v, (n + 2) * 2);
        check_payload($sformatf("R2 vec%0d payload", i), 0, n, i * 256);
        release_head();
        chk($sformatf("R7 vec%0d released", i), int'(rx_irq), 0);
      end
    end
    allow_bad_crc = 1'b0;

    // disabled reception (R8)
    v = wr_count;
    rx_enable = 1'b0;
    send_frame(6, 1'b1, 16'h0a00);
    chk("R8 no write while disabled", wr_count - v, 0);
    chk("R8 not queued", int'(rx_irq), 0);
    rx_enable = 1'b1;

    // release on empty queue (R7)
    release_head();
    chk("R7 empty release irq", int'(rx_irq), 0);
    send_frame(6, 1'b1, 16'h0b00);
    chk("R7 R1 pkt after empty release", int'(rx_head_pkt), 0);
    release_head();

    // page exhaustion and queue order (R1 R6 R7)
    send_frame(20, 1'b1, 16'h1000);
    send_frame(20, 1'b1, 16'h2000);
    chk("R1 second pkt number", int'(rx_head_pkt), 0);
    v = wr_count;
    send_frame(3, 1'b1, 16'h3000);
    chk("R1 no page no write", wr_count - v, 0);
    chk("R6 head unchanged", int'(rx_head_pkt), 0);
    release_head();
    chk("R6 order head next", int'(rx_head_pkt), 1);
    send_frame(3, 1'b1, 16'h3000);
    release_head();
    chk("R7 reused pkt at head", int'(rx_head_pkt), 0);
    check_payload("R7 R2 reused pages payload", 0, 3, 16'h3000);
    release_head();
    chk("R7 all released", int'(rx_irq), 0);

    // overrun frees everything (R3)
    send_frame(25, 1'b1, 16'h4000);
    chk("R3 overrun not queued", int'(rx_irq), 0);
    send_frame(20, 1'b1, 16'h5000);
    send_frame(20, 1'b1, 16'h6000);
    chk("R3 first after overrun", int'(rx_head_pkt), 0);
    check_payload("R3 payload after overrun", 0, 20, 16'h5000);
    release_head();
    chk("R3 second after overrun", int'(rx_head_pkt), 1);
    check_payload("R3 second payload", 1, 20, 16'h6000);
    release_head();
    chk("R3 queue empty", int'(rx_irq), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule